// File: doc/BRIEF.md
# Single to Double Precision Widening Converter

This unit takes a 32-bit IEEE single-precision word and produces the exactly equivalent 64-bit double-precision register image. A one-cycle `start` strobe presents the word. One cycle later a one-cycle `done` pulse marks the finished result, which stays on `dword_out` until the next conversion completes. Widening is always exact, so the unit has no rounding logic and raises no exception flags.

Normal numbers, zeros, infinities and NaNs are widened by direct field copying. The 8-bit exponent becomes 11 bits by keeping its top bit and filling three new bits. For normal numbers the fill is the inverse of that top bit, which rebiases the exponent from 127 to 1023. For all-zero and all-ones exponents the fill is a copy of the top bit. Single-precision subnormals have no hidden bit, and the double format can hold them as normal numbers. The unit normalizes them with a left-shift loop that runs one shift per clock. While that loop runs, further `start` strobes are ignored.

Bit positions below count from the least significant bit. Input: sign at bit 31, exponent at bits 30:23, fraction at bits 22:0. Output: sign at bit 63, exponent at bits 62:52, fraction at bits 51:0.

Top module: `sp_to_dp_widen`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `done` low and `dword_out` all zero, with no conversion in progress.
- R2: For an input exponent from 1 to 254, the result is {bit 31, bit 30, three copies of the inverse of bit 30, bits 29:0, 29 zeros}. `done` is high for the cycle that follows the edge that sampled `start`.
- R3: An input whose bits 30:0 are all zero gives {bit 31, 63 zeros}, with the same one-cycle latency as R2.
- R4: An input exponent of 255 gives {bit 31, 11 ones, bits 22:0, 29 zeros}, so infinity stays infinity and the NaN payload is kept. The latency is the same as R2.
- R5: For an input exponent of 0 with a nonzero fraction, let z be the number of leading zeros of the 23-bit fraction. The result has sign bit 31, exponent field 896 − z, and fraction field equal to the input fraction shifted left by z+1 and padded with zeros to 52 bits. The leading one is dropped.
- R6: A subnormal result's `done` is high after z+2 rising edges, counting the edge that sampled `start`. The longest case is 24 edges, for fraction 1.
- R7: `done` is high for exactly one cycle per accepted conversion. `dword_out` changes only when `done` rises and holds its value between results.
- R8: A `start` that arrives while a subnormal is being normalized is ignored. This includes the edge on which that conversion completes.
- R9: A `start` on the cycle in which `done` is high is accepted when the unit is idle, so normal inputs may be issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe: sample `word_in` and begin a conversion |
| word_in | input | 32 | Single-precision input word |
| done | output | 1 | One-cycle pulse: `dword_out` holds a new result |
| dword_out | output | 64 | Double-precision result, held between conversions |

## Verification
A working exponent or fraction that drifts during the shift loop appears on `dword_out` at the `done` edge. A wrong leading-one detection shows first as `done` arriving a cycle early or late, which the per-cycle comparison catches at that exact edge. A busy flag that fails to clear or set shows up either as a lost result or as a second `done` for a `start` that should have been ignored. The denormal cases cover every leading-zero count from 0 to 22 at the extremes and in between. Each output bit is compared on every cycle, so a mismatch is reported within the cycle it appears.

// File: rtl/s2d_pkg.sv
package s2d_pkg;

    parameter int SP_EXP_W  = 8;
    parameter int SP_FRAC_W = 23;
    parameter int DP_EXP_W  = 11;
    parameter int DP_FRAC_W = 52;
    parameter int SP_BIAS   = 127;
    parameter int DP_BIAS   = 1023;

    localparam int SP_W     = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W     = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int FILL_W   = DP_EXP_W - SP_EXP_W;
    localparam int PAD_W    = DP_FRAC_W - SP_FRAC_W;
    localparam int WORK_W   = DP_FRAC_W + 1;
    localparam int CNT_W    = $clog2(SP_FRAC_W + 1);
    // biased double exponent of the smallest single normal
    localparam int SUB_BASE = DP_BIAS - (SP_BIAS - 1);

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_t;

    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
    } dp_t;

    typedef enum logic [1:0] {
        CLS_NORMAL,
        CLS_ZERO,
        CLS_SPECIAL,
        CLS_SUBNORM
    } cls_e;

    function automatic cls_e classify(input sp_t w);
        if (w.exp == '0)
            return (w.frac == '0) ? CLS_ZERO : CLS_SUBNORM;
        if (w.exp == '1)
            return CLS_SPECIAL;
        return CLS_NORMAL;
    endfunction

    function automatic dp_t widen_direct(input sp_t w, input cls_e c);
        dp_t r;
        logic top;
        top     = w.exp[SP_EXP_W-1];
        r.sign  = w.sign;
        r.exp   = {top, {FILL_W{(c == CLS_NORMAL) ? ~top : top}},
                   w.exp[SP_EXP_W-2:0]};
        r.frac  = {w.frac, {PAD_W{1'b0}}};
        return r;
    endfunction

endpackage

// File: rtl/s2d_classify.sv
module s2d_classify
    import s2d_pkg::*;
(
    input  sp_t  word,
    output cls_e cls
);
    always_comb cls = classify(word);
endmodule

// File: rtl/s2d_direct_map.sv
module s2d_direct_map
    import s2d_pkg::*;
(
    input  sp_t  word,
    input  cls_e cls,
    output dp_t  result
);
    always_comb result = widen_direct(word, cls);
endmodule

// File: rtl/s2d_norm_engine.sv
module s2d_norm_engine
    import s2d_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 sign_in,
    input  logic [SP_FRAC_W-1:0] frac_in,
    output logic                 busy,
    output logic                 finish,
    output dp_t                  result
);
    logic                busy_q;
    logic                sign_q;
    logic [WORK_W-1:0]   work_q;
    logic [DP_EXP_W-1:0] exp_q;
    logic [CNT_W-1:0]    iter_q;
    logic [WORK_W-1:0]   shifted;

    always_comb begin
        shifted = work_q << 1;
        busy    = busy_q;
        // the next shift brings a one into the leading position
        finish  = busy_q && work_q[WORK_W-2];
        result.sign = sign_q;
        result.exp  = exp_q - DP_EXP_W'(1);
        result.frac = shifted[DP_FRAC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sign_q <= 1'b0;
            work_q <= '0;
            exp_q  <= '0;
            iter_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            sign_q <= sign_in;
            work_q <= {1'b0, frac_in, {PAD_W{1'b0}}};
            exp_q  <= DP_EXP_W'(SUB_BASE);
            iter_q <= '0;
        end else if (busy_q) begin
            work_q <= shifted;
            exp_q  <= exp_q - DP_EXP_W'(1);
            iter_q <= iter_q + CNT_W'(1);
            if (work_q[WORK_W-2])
                busy_q <= 1'b0;
        end
    end

    // R6
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (iter_q < CNT_W'(SP_FRAC_W)));

    // R5
    sub_exp_range_chk: assert property (@(posedge clk) disable iff (rst)
        finish |-> (result.exp >= DP_EXP_W'(SUB_BASE - SP_FRAC_W)) &&
                   (result.exp <= DP_EXP_W'(SUB_BASE - 1)));

    // R8
    work_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !finish) |=> (busy_q && $stable(sign_q)));

    // R6
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy_q);
endmodule

// File: rtl/sp_to_dp_widen.sv
module sp_to_dp_widen
    import s2d_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [SP_W-1:0] word_in,
    output logic            done,
    output logic [DP_W-1:0] dword_out
);
    sp_t  word;
    cls_e cls;
    dp_t  direct_res;
    dp_t  eng_res;
    logic eng_busy;
    logic eng_finish;
    logic accept;
    logic take_direct;
    logic take_sub;
    logic done_q;
    dp_t  out_q;

    always_comb begin
        word        = sp_t'(word_in);
        accept      = start && !eng_busy;
        take_direct = accept && (cls != CLS_SUBNORM);
        take_sub    = accept && (cls == CLS_SUBNORM);
    end

    s2d_classify u_cls (
        .word (word),
        .cls  (cls)
    );

    s2d_direct_map u_map (
        .word   (word),
        .cls    (cls),
        .result (direct_res)
    );

    s2d_norm_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .load    (take_sub),
        .sign_in (word.sign),
        .frac_in (word.frac),
        .busy    (eng_busy),
        .finish  (eng_finish),
        .result  (eng_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            out_q  <= '0;
        end else if (take_direct) begin
            done_q <= 1'b1;
            out_q  <= direct_res;
        end else if (eng_finish) begin
            done_q <= 1'b1;
            out_q  <= eng_res;
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done      = done_q;
    assign dword_out = out_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!done && dword_out == '0));

    // R2
    direct_latency_chk: assert property (@(posedge clk) disable iff (rst)
        take_direct |=> done);

    // R7
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(take_direct) || $past(eng_finish)));

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(dword_out));
endmodule

// File: tb/sp_to_dp_widen_test.sv
module sp_to_dp_widen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] word_in;
    logic        done;
    logic [63:0] dword_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    // model state
    int          m_cnt = 0;
    logic [63:0] m_pend = '0;
    logic        exp_done = 1'b0;
    logic [63:0] exp_out = '0;
    string       cls_tag = "R1";
    string       m_pend_tag = "R1";
    string       scen = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_to_dp_widen uut (
        .clk(clk), .rst(rst), .start(start), .word_in(word_in),
        .done(done), .dword_out(dword_out)
    );

    function automatic int lead_zeros(input logic [22:0] f);
        int n = 0;
        logic [22:0] m = f;
        while (!m[22] && n < 23) begin
            m = m << 1;
            n++;
        end
        return n;
    endfunction

    function automatic logic [63:0] ref_conv(input logic [31:0] w);
        logic [7:0]  e;
        logic [22:0] f;
        int          z;
        logic [22:0] m;
        e = w[30:23];
        f = w[22:0];
        if (e == 8'd0 && f == 23'd0) return {w[31], 63'd0};
        if (e == 8'd255) return {w[31], 11'h7FF, f, 29'd0};
        if (e != 8'd0) return {w[31], 11'(int'(e) - 127 + 1023), f, 29'd0};
        z = lead_zeros(f);
        m = f << z;
        return {w[31], 11'(896 - z), m[21:0], 30'd0};
    endfunction

    function automatic int ref_lat(input logic [31:0] w);
        if (w[30:23] == 8'd0 && w[22:0] != 23'd0) return lead_zeros(w[22:0]) + 2;
        return 1;
    endfunction

    function automatic string ref_tag(input logic [31:0] w);
        if (w[30:23] == 8'd255) return "R4";
        if (w[30:0] == 31'd0) return "R3";
        if (w[30:23] == 8'd0) return "R5 R6";
        return "R2";
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        cycles++;
        exp_done = 1'b0;
        if (rst) begin
            m_cnt   = 0;
            exp_out = '0;
            cls_tag = "R1";
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                exp_done = 1'b1;
                exp_out  = m_pend;
                cls_tag  = m_pend_tag;
            end
        end else if (start) begin
            m_pend     = ref_conv(word_in);
            m_pend_tag = ref_tag(word_in);
            if (ref_lat(word_in) == 1) begin
                exp_done = 1'b1;
                exp_out  = m_pend;
                cls_tag  = m_pend_tag;
            end else begin
                m_cnt = ref_lat(word_in) - 1;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (done !== exp_done) begin
                fails++;
                $display("FAIL %s %s R7: done=%0b expected %0b at cycle %0d",
                         scen, cls_tag, done, exp_done, cycles);
            end
            checks++;
            if (dword_out !== exp_out) begin
                fails++;
                $display("FAIL %s %s: dword_out=%h expected %h at cycle %0d",
                         scen, cls_tag, dword_out, exp_out, cycles);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic settle();
        @(negedge clk);
        while (m_cnt != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [31:0] w);
        start   = 1'b1;
        word_in = w;
        @(negedge clk);
        start   = 1'b0;
        word_in = 32'hDEAD_BEEF;
        settle();
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; word_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state observed by the per-cycle compare
        scen = "R1";
        start = 1'b1; word_in = 32'h3F80_0000;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R2 normal values
        scen = "R2";
        issue(32'h3F80_0000);
        issue(32'hC049_0FDB);
        issue(32'h0080_0000);
        issue(32'h7F7F_FFFF);
        issue(32'h8123_4567);
        // R3 zeros
        scen = "R3";
        issue(32'h0000_0000);
        issue(32'h8000_0000);
        // R4 infinities and NaNs
        scen = "R4";
        issue(32'h7F80_0000);
        issue(32'hFF80_0000);
        issue(32'h7FC0_0001);
        issue(32'hFFA5_5A5A);
        // R5 R6 subnormals, all leading-zero counts
        scen = "R5";
        for (int i = 0; i < 23; i++) issue(32'h0000_0001 << i);
        issue(32'h8000_0001);
        issue(32'h0012_3456);
        issue(32'h807F_FFFF);
        issue(32'h0000_0003);
        // R8 start pulse during normalization ignored
        scen = "R8";
        start = 1'b1; word_in = 32'h0000_0001;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; word_in = 32'h3F80_0000;
        @(negedge clk);
        start = 1'b0;
        settle();
        // R8 start held high through a conversion
        start = 1'b1; word_in = 32'h0000_0010;
        repeat (45) @(negedge clk);
        start = 1'b0;
        settle();
        // R9 back-to-back normal starts
        scen = "R9";
        start = 1'b1; word_in = 32'h4000_0000;
        @(negedge clk);
        word_in = 32'hBF00_0000;
        @(negedge clk);
        word_in = 32'h7F80_0000;
        @(negedge clk);
        word_in = 32'h0040_0000;
        @(negedge clk);
        start = 1'b0;
        settle();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule